// File: doc/BRIEF.md
# Transmit Descriptor Sequencer

This block drives the send path of a small packet network controller. Software sees four transmit slots. Each slot has a 32-bit buffer-address register and a 32-bit status/command register. Software first loads the address of a frame in memory. It then writes the frame length and an early-start threshold into the slot's status register, and that write passes the slot to hardware. The sequencer serves the slots in a fixed rotation. It fetches the frame one byte per request from a memory read port with one cycle of latency, and delivers it on a valid/ready byte stream with an end-of-frame flag.

A small staging FIFO sits between the fetch and the stream. No byte leaves the FIFO until enough bytes have been fetched, and the threshold field sets how many that is. When the final byte is accepted, the slot is handed back to software with a success flag and a completion interrupt is raised. A slot whose length is out of range is handed back at once with an error interrupt. In that case the rotation does not move past it until software reprograms it. Adding the frame check sequence, padding short frames, the line interface and the bus protocol all happen outside this block.

Top module: `nic_tx_sequencer`

## Requirements
- R1: After reset, every slot status reads 0x0000_2000 (bit 13, host-owned, set; all else 0), every slot address reads 0, the interrupt register at 0x3C reads 0, and `irq`, `txValid` and `memRdEn` are low.
- R2: A write to a host-owned slot loads its registers. For slot n the status register is at 0x10+4n and the address register at 0x20+4n. The status write stores the length from bits 12:0 and the threshold from bits 21:16, and clears bit 13 (host-owned) and bit 15 (sent OK). The status reads back as {10'b0, threshold, ok, 1'b0, host-owned, length}.
- R3: A launched slot streams exactly `length` bytes, taken in order from addresses base, base+1, and onward. `txLast` is high only on the final byte. Short frames are sent as programmed, with no padding. While `txValid` is high and `txReady` is low, `txData` and `txLast` hold their values.
- R4: One cycle after the final byte is accepted, the slot status has bit 13 and bit 15 set, with length and threshold unchanged, interrupt bit 2 is set and `irq` is high.
- R5: Slots are launched strictly in the order 0,1,2,3,0. A slot handed to hardware out of turn waits until the rotation reaches it. The rotation moves on only after a successful completion.
- R6: A length of 0 or above 1514 issues no memory reads and streams nothing. It returns the slot with bit 13 set and bit 15 clear, and sets interrupt bit 3. The rotation stays on that slot.
- R7: No byte is presented until the number of fetched bytes reaches min(threshold×32, length, FIFO depth).
- R8: Writing 1 to bit 2 or bit 3 of the register at 0x3C clears that bit, and writing 0 leaves it unchanged. If a completion sets a bit in the same cycle that the host clears it, the bit stays set. `irq` is the OR of bits 2 and 3.
- R9: Writes to the address or status register of a slot that hardware owns are ignored, and the transfer in progress is not disturbed.
- R10: A synchronous reset during a transfer stops streaming, returns all slots to host-owned, and resets the rotation to slot 0.
- R11: Memory reads that have been issued but whose bytes have not yet been sent never exceed the FIFO depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset for reads and writes |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| irq | output | 1 | Transmit interrupt, OR of pending bits |
| memRdEn | output | 1 | Memory byte read request |
| memRdAddr | output | 32 | Memory byte address |
| memRdData | input | 8 | Memory data, valid the cycle after the request |
| txValid | output | 1 | Stream byte valid |
| txData | output | 8 | Stream byte |
| txLast | output | 1 | Final byte of the frame |
| txReady | input | 1 | Stream sink ready |

## Verification
A frame can finish in the same cycle that software writes 1 to clear the completion interrupt bit. The set and the clear then reach the same flop on the same edge. The bench provokes this with a one-byte frame. It holds `txReady` low until that byte is presented, then raises `txReady` in the very cycle it issues the clear write to 0x3C. The bench then reads the interrupt register and expects bit 2 to still be set, because a new completion must never be lost to an older acknowledge.

// File: rtl/nic_tx_pkg.sv
package nic_tx_pkg;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W    = 2;
  localparam int LEN_W     = 13;
  localparam int THR_W     = 6;
  localparam int ADDR_W    = 32;
  localparam int THR_LSB   = 16;

  localparam logic [7:0] STAT_BASE = 8'h10;
  localparam logic [7:0] ADDR_BASE = 8'h20;
  localparam logic [7:0] INT_OFS   = 8'h3C;

  localparam int INT_OK_BIT  = 2;
  localparam int INT_ERR_BIT = 3;

  // control -> datapath launch strobe with its operands
  typedef struct packed {
    logic              start;
    logic [ADDR_W-1:0] base;
    logic [LEN_W-1:0]  len;
    logic [LEN_W-1:0]  gate;
  } txCmd_t;

  // datapath -> control events
  typedef struct packed {
    logic frameDone;
  } txEvt_t;
endpackage

// File: rtl/nic_tx_control.sv
module nic_tx_control
  import nic_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int MAX_FRAME  = 1514
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        irq,
  output txCmd_t      cmd,
  input  txEvt_t      evt
);
  logic [ADDR_W-1:0]    slotBase [NUM_SLOTS];
  logic [LEN_W-1:0]     slotLen  [NUM_SLOTS];
  logic [THR_W-1:0]     slotThr  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slotHost;
  logic [NUM_SLOTS-1:0] slotOk;
  logic [SLOT_W-1:0]    curSlot;
  logic                 busy;
  logic                 intOk;
  logic                 intErr;

  // address decode
  logic [SLOT_W-1:0] hitIdx;
  logic statSel, addrSel, intSel;
  assign hitIdx  = regAddr[SLOT_W+1:2];
  assign statSel = (regAddr[1:0] == 2'b00) && (regAddr[7:4] == STAT_BASE[7:4]);
  assign addrSel = (regAddr[1:0] == 2'b00) && (regAddr[7:4] == ADDR_BASE[7:4]);
  assign intSel  = (regAddr == INT_OFS);

  // launch decision for the slot at the head of the rotation
  logic curReady, lenBad, launchGood, launchBad;
  assign curReady   = !busy && !slotHost[curSlot];
  assign lenBad     = (slotLen[curSlot] == '0) ||
                      (slotLen[curSlot] > LEN_W'(MAX_FRAME));
  assign launchGood = curReady && !lenBad;
  assign launchBad  = curReady && lenBad;

  // early-start gate: min(threshold*32, length, FIFO depth)
  logic [LEN_W-1:0] thrBytes, gateLen;
  assign thrBytes = LEN_W'({slotThr[curSlot], 5'b0_0000});
  always_comb begin
    gateLen = (thrBytes < slotLen[curSlot]) ? thrBytes : slotLen[curSlot];
    if (gateLen > LEN_W'(FIFO_DEPTH)) gateLen = LEN_W'(FIFO_DEPTH);
  end

  assign cmd.start = launchGood;
  assign cmd.base  = slotBase[curSlot];
  assign cmd.len   = slotLen[curSlot];
  assign cmd.gate  = gateLen;

  // slot registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < NUM_SLOTS; g++) begin
        slotBase[g] <= '0;
        slotLen[g]  <= '0;
        slotThr[g]  <= '0;
        slotHost[g] <= 1'b1;
        slotOk[g]   <= 1'b0;
      end
    end else begin
      for (int g = 0; g < NUM_SLOTS; g++) begin
        if (regWrEn && addrSel && hitIdx == SLOT_W'(g) && slotHost[g])
          slotBase[g] <= regWrData;
        if (regWrEn && statSel && hitIdx == SLOT_W'(g) && slotHost[g]) begin
          slotLen[g]  <= regWrData[LEN_W-1:0];
          slotThr[g]  <= regWrData[THR_LSB +: THR_W];
          slotHost[g] <= 1'b0;
          slotOk[g]   <= 1'b0;
        end else if (curSlot == SLOT_W'(g) && (evt.frameDone || launchBad)) begin
          slotHost[g] <= 1'b1;
          slotOk[g]   <= evt.frameDone;
        end
      end
    end
  end

  // rotation, busy flag, interrupt bits (a new event wins over a clear)
  logic clrOk, clrErr;
  assign clrOk  = regWrEn && intSel && regWrData[INT_OK_BIT];
  assign clrErr = regWrEn && intSel && regWrData[INT_ERR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      curSlot <= '0;
      busy    <= 1'b0;
      intOk   <= 1'b0;
      intErr  <= 1'b0;
    end else begin
      if (launchGood) busy <= 1'b1;
      if (evt.frameDone) begin
        busy    <= 1'b0;
        curSlot <= curSlot + 1'b1;
      end
      intOk  <= (intOk  && !clrOk)  || evt.frameDone;
      intErr <= (intErr && !clrErr) || launchBad;
    end
  end

  assign irq = intOk || intErr;

  // read-back words per slot
  logic [31:0] statWord [NUM_SLOTS];
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gStatWord
    assign statWord[g] = {10'b0, slotThr[g], slotOk[g], 1'b0, slotHost[g], slotLen[g]};
  end

  always_comb begin
    regRdData = '0;
    if (statSel)     regRdData = statWord[hitIdx];
    else if (addrSel) regRdData = slotBase[hitIdx];
    else if (intSel) begin
      regRdData[INT_OK_BIT]  = intOk;
      regRdData[INT_ERR_BIT] = intErr;
    end
  end
endmodule

// File: rtl/nic_tx_datapath.sv
module nic_tx_datapath
  import nic_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  txCmd_t            cmd,
  output txEvt_t            evt,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [7:0]        memRdData,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              txLast,
  input  logic              txReady
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic              active;
  logic [ADDR_W-1:0] fetchAddr;
  logic [LEN_W-1:0]  fetchLeft;
  logic [LEN_W-1:0]  fetchedCnt;
  logic [LEN_W-1:0]  sendLeft;
  logic [LEN_W-1:0]  gateTarget;
  logic              pendValid;
  logic [7:0]        fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fifoCnt;

  logic roomOk, gateOpen, pop;
  assign roomOk   = (fifoCnt + CNT_W'(pendValid)) < CNT_W'(FIFO_DEPTH);
  assign memRdEn  = active && (fetchLeft != '0) && roomOk;
  assign memRdAddr = fetchAddr;
  assign gateOpen = fetchedCnt >= gateTarget;
  assign txValid  = active && (fifoCnt != '0) && gateOpen;
  assign txData   = fifoMem[rdPtr];
  assign txLast   = (sendLeft == LEN_W'(1));
  assign pop      = txValid && txReady;
  assign evt.frameDone = pop && txLast;

  always_ff @(posedge clk) begin
    if (pendValid) fifoMem[wrPtr] <= memRdData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      fetchAddr  <= '0;
      fetchLeft  <= '0;
      fetchedCnt <= '0;
      sendLeft   <= '0;
      gateTarget <= '0;
      pendValid  <= 1'b0;
      wrPtr      <= '0;
      rdPtr      <= '0;
      fifoCnt    <= '0;
    end else if (cmd.start) begin
      active     <= 1'b1;
      fetchAddr  <= cmd.base;
      fetchLeft  <= cmd.len;
      fetchedCnt <= '0;
      sendLeft   <= cmd.len;
      gateTarget <= cmd.gate;
      pendValid  <= 1'b0;
      wrPtr      <= '0;
      rdPtr      <= '0;
      fifoCnt    <= '0;
    end else begin
      pendValid <= memRdEn;
      if (memRdEn) begin
        fetchAddr <= fetchAddr + 1'b1;
        fetchLeft <= fetchLeft - 1'b1;
      end
      if (pendValid) begin
        wrPtr      <= wrPtr + 1'b1;
        fetchedCnt <= fetchedCnt + 1'b1;
      end
      if (pop) begin
        rdPtr    <= rdPtr + 1'b1;
        sendLeft <= sendLeft - 1'b1;
      end
      fifoCnt <= fifoCnt + CNT_W'(pendValid) - CNT_W'(pop);
      if (evt.frameDone) active <= 1'b0;
    end
  end
endmodule

// File: rtl/nic_tx_sequencer.sv
module nic_tx_sequencer
  import nic_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int MAX_FRAME  = 1514
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        irq,
  output logic        memRdEn,
  output logic [31:0] memRdAddr,
  input  logic [7:0]  memRdData,
  output logic        txValid,
  output logic [7:0]  txData,
  output logic        txLast,
  input  logic        txReady
);
  txCmd_t cmd;
  txEvt_t evt;

  nic_tx_control #(.FIFO_DEPTH(FIFO_DEPTH), .MAX_FRAME(MAX_FRAME)) u_ctrl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq),
    .cmd(cmd), .evt(evt)
  );

  nic_tx_datapath #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rst(rst), .cmd(cmd), .evt(evt),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .txValid(txValid), .txData(txData), .txLast(txLast), .txReady(txReady)
  );
endmodule

// File: rtl/nic_tx_sequencer_checker.sv
module nic_tx_sequencer_checker #(
  parameter int FIFO_DEPTH = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       txValid,
  input logic       txReady,
  input logic [7:0] txData,
  input logic       txLast,
  input logic       memRdEn,
  input logic       irq
);
  logic [15:0] outstanding;
  always_ff @(posedge clk) begin
    if (rst) outstanding <= '0;
    else outstanding <= outstanding + 16'(memRdEn) - 16'(txValid && txReady);
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txLast))); // R3

  AST_IRQ_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (txValid && txReady && txLast) |=> irq); // R4

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!txValid && !memRdEn && !irq)); // R10

  AST_FIFO_ROOM: assert property (@(posedge clk) disable iff (rst)
    outstanding <= 16'(FIFO_DEPTH)); // R11
endmodule

bind nic_tx_sequencer nic_tx_sequencer_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_check (
  .clk(clk), .rst(rst), .txValid(txValid), .txReady(txReady), .txData(txData),
  .txLast(txLast), .memRdEn(memRdEn), .irq(irq)
);

// File: tb/nic_tx_sequencer_bench.sv
module nic_tx_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq, memRdEn, txValid, txLast;
  logic [31:0] memRdAddr;
  logic [7:0]  memRdData = '0;
  logic [7:0]  txData;
  logic        txReady = 1'b1;

  always #2 clk = ~clk;

  nic_tx_sequencer u_nic_tx_sequencer (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .txValid(txValid), .txData(txData), .txLast(txLast), .txReady(txReady)
  );

  int checks = 0, failures = 0, cyc = 0, readyMode = 0;
  logic [7:0] capData [4096];
  logic       capLast [4096];
  int capCount = 0, reqCount = 0, reqAtFirst = -1;
  bit seenValid = 0;

  // stimulus/expected table: slot, base, length, threshold, ready mode, expected gate
  localparam int VN = 5;
  localparam int VSLOT [VN] = '{0, 1, 2, 3, 0};
  localparam int VBASE [VN] = '{32'h1000, 32'h2040, 32'h30F0, 32'h4000, 32'h50FE};
  localparam int VLEN  [VN] = '{60, 100, 33, 64, 1514};
  localparam int VTHR  [VN] = '{8, 1, 0, 63, 8};
  localparam int VMODE [VN] = '{0, 1, 0, 1, 0};
  localparam int VGATE [VN] = '{60, 32, 0, 64, 64};

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) if (memRdEn) memRdData <= memByte(memRdAddr);

  always @(negedge clk) begin
    cyc++;
    case (readyMode)
      0: txReady = 1'b1;
      1: txReady = (cyc % 3) != 0;
      2: txReady = 1'b0;
      default: txReady = 1'b1;
    endcase
  end

  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (memRdEn) reqCount++;
      if (txValid && !seenValid) begin seenValid = 1; reqAtFirst = reqCount; end
      if (txValid && txReady && capCount < 4096) begin
        capData[capCount] = txData;
        capLast[capCount] = txLast;
        capCount++;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic clearCap();
    capCount = 0; reqCount = 0; seenValid = 0; reqAtFirst = -1;
  endtask

  task automatic waitBytes(input int n);
    int t = 0;
    while (capCount < n && t < 6000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic checkFrame(input int at, input logic [31:0] base, input int len, input string req);
    int bad = 0;
    logic [31:0] act = '0, exp = '0;
    for (int i = 0; i < len; i++) begin
      logic [7:0] e = memByte(base + 32'(i));
      if (bad == 0 && (capData[at+i] !== e || capLast[at+i] !== (i == len - 1))) begin
        bad = 1;
        act = {15'b0, capLast[at+i], 8'h00, capData[at+i]};
        exp = {15'b0, (i == len - 1) ? 1'b1 : 1'b0, 8'h00, e};
      end
    end
    chk(bad == 0, req, act, exp);
  endtask

  task automatic launch(input int slot, input logic [31:0] base, input logic [31:0] stat);
    regWrite(8'h20 + 8'(4 * slot), base);
    regWrite(8'h10 + 8'(4 * slot), stat);
  endtask

  initial begin
    logic [31:0] rd, stat;
    int allOk;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    allOk = 1;
    for (int s = 0; s < 4; s++) begin
      regRead(8'h10 + 8'(4 * s), rd); if (rd !== 32'h2000) allOk = 0;
      regRead(8'h20 + 8'(4 * s), rd); if (rd !== 32'h0) allOk = 0;
    end
    chk(allOk == 1, "R1 slot regs", 32'(allOk), 32'd1);
    regRead(8'h3C, rd);
    chk(rd === 32'h0 && irq === 1'b0, "R1 int/irq", rd, 32'h0);
    chk(txValid === 1'b0 && memRdEn === 1'b0, "R1 idle", {30'b0, txValid, memRdEn}, 32'h0);

    // table walk: R2 R3 R4 R5 R7 (R9 inside the long frame)
    for (int v = 0; v < VN; v++) begin
      clearCap();
      readyMode = VMODE[v];
      stat = (32'(VTHR[v]) << 16) | 32'(VLEN[v]);
      launch(VSLOT[v], 32'(VBASE[v]), stat);
      regRead(8'h10 + 8'(4 * VSLOT[v]), rd);
      chk(rd === stat, "R2 status after handoff", rd, stat);
      if (v == 4) begin
        regWrite(8'h10, 32'h0000_0005);   // R9 ignored writes
        regWrite(8'h20, 32'hDEAD_0000);
      end
      waitBytes(VLEN[v]);
      chk(capCount == VLEN[v], "R3 byte count", 32'(capCount), 32'(VLEN[v]));
      checkFrame(0, 32'(VBASE[v]), VLEN[v], "R3 frame content");
      chk(reqAtFirst >= VGATE[v] && reqAtFirst <= VGATE[v] + 3, "R7 early-start gate",
          32'(reqAtFirst), 32'(VGATE[v]));
      regRead(8'h10 + 8'(4 * VSLOT[v]), rd);
      chk(rd === (stat | 32'hA000), "R4 status on completion", rd, stat | 32'hA000);
      regRead(8'h3C, rd);
      chk(rd[2] === 1'b1 && irq === 1'b1, "R4 interrupt", rd, 32'h4);
      if (v == 4) begin
        regRead(8'h20, rd);
        chk(rd === 32'(VBASE[v]), "R9 address write ignored", rd, 32'(VBASE[v]));
      end
    end
    readyMode = 0;

    // R5 out-of-turn slot waits (rotation now at slot 1)
    clearCap();
    launch(3, 32'h6000, 32'd20);
    repeat (40) @(negedge clk);
    chk(capCount == 0 && reqCount == 0, "R5 out-of-turn slot held", 32'(capCount), 32'h0);
    regRead(8'h1C, rd);
    chk(rd === 32'd20, "R5 waiting slot status", rd, 32'd20);
    launch(1, 32'h7000, 32'd12);
    waitBytes(12);
    repeat (30) @(negedge clk);
    chk(capCount == 12, "R5 only slot 1 sent", 32'(capCount), 32'd12);
    checkFrame(0, 32'h7000, 12, "R5 slot 1 frame");
    launch(2, 32'h7100, 32'd9);
    waitBytes(41);
    checkFrame(12, 32'h7100, 9, "R5 slot 2 frame");
    checkFrame(21, 32'h6000, 20, "R5 slot 3 frame");

    // R8 completion and clear in the same cycle (rotation at slot 0)
    clearCap();
    readyMode = 2;
    launch(0, 32'h8000, 32'd1);
    while (!seenValid && cyc < 90000) @(negedge clk);
    #1;
    readyMode = 3;
    regWrite(8'h3C, 32'h4);
    repeat (3) @(negedge clk);
    chk(capCount == 1, "R8 collision frame sent", 32'(capCount), 32'd1);
    regRead(8'h3C, rd);
    chk(rd === 32'h4, "R8 set wins over clear", rd, 32'h4);
    readyMode = 0;
    regWrite(8'h3C, 32'h0);
    regRead(8'h3C, rd);
    chk(rd === 32'h4, "R8 write of zero keeps bit", rd, 32'h4);
    regWrite(8'h3C, 32'h4);
    regRead(8'h3C, rd);
    chk(rd === 32'h0 && irq === 1'b0, "R8 write-one clears", rd, 32'h0);

    // R6 bad lengths (rotation at slot 1)
    clearCap();
    launch(1, 32'h9000, 32'd0);
    repeat (10) @(negedge clk);
    regRead(8'h14, rd);
    chk(rd === 32'h2000, "R6 zero length returned", rd, 32'h2000);
    regRead(8'h3C, rd);
    chk(rd === 32'h8 && irq === 1'b1, "R6 error interrupt", rd, 32'h8);
    launch(2, 32'h9100, 32'd10);
    repeat (30) @(negedge clk);
    chk(capCount == 0 && reqCount == 0, "R6 rotation held on failed slot", 32'(reqCount), 32'h0);
    regWrite(8'h3C, 32'h8);
    launch(1, 32'h9000, 32'd1515);
    repeat (10) @(negedge clk);
    regRead(8'h14, rd);
    chk(rd === 32'h25EB, "R6 oversize returned", rd, 32'h25EB);
    regRead(8'h3C, rd);
    chk(rd === 32'h8 && reqCount == 0, "R6 oversize error, no reads", rd, 32'h8);
    regWrite(8'h3C, 32'h8);
    launch(1, 32'h9000, 32'd5);
    waitBytes(15);
    checkFrame(0, 32'h9000, 5, "R6 retried slot");
    checkFrame(5, 32'h9100, 10, "R6 following slot");

    // R10 reset mid-transfer (rotation at slot 3)
    clearCap();
    launch(3, 32'hA000, (32'd8 << 16) | 32'd1000);
    repeat (120) @(negedge clk);
    chk(capCount > 0 && capCount < 1000, "R10 transfer in progress", 32'(capCount), 32'd1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1 chk(txValid === 1'b0 && irq === 1'b0, "R10 stream stopped", {30'b0, txValid, irq}, 32'h0);
    allOk = 1;
    for (int s = 0; s < 4; s++) begin
      regRead(8'h10 + 8'(4 * s), rd); if (rd !== 32'h2000) allOk = 0;
    end
    chk(allOk == 1, "R10 slots host-owned", 32'(allOk), 32'd1);
    clearCap();
    launch(0, 32'hB000, 32'd8);
    waitBytes(8);
    chk(capCount == 8, "R10 rotation back at slot 0", 32'(capCount), 32'd8);
    checkFrame(0, 32'hB000, 8, "R10 frame after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule